// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Generator

This block answers the processor's interrupt acknowledge cycles by placing vector bytes on the data bus. It supports two processor styles. In the 8-bit call style, three acknowledge pulses fetch a call instruction: an opcode byte first, then the low and high bytes of a service routine address. The low byte is built from the programmed base bits and the acknowledged level, spaced 4 or 8 bytes apart. In the 16-bit vector style, two pulses are issued. The first pulse reads nothing, and the second returns one vector byte: five programmed upper bits joined to the three-bit level.

The level and the processor style are captured on the first pulse of a sequence and held until its last pulse. That pulse also raises a one-cycle sequence-end strobe, which can trigger automatic end-of-interrupt. In a cascaded system a master gives the address bytes to the slave that owns the acknowledged level. A slave drives only the address bytes, and only when it is selected. Each acknowledge pulse is detected on the rising edge of `ack_i`. The drive enable stays high for as long as the pulse lasts.

Top module: `ivg_ack_vector`

## Requirements
- R1: After reset, `drv_en_o`, `seq_end_o` and `byte_o` are 0, and the next acknowledge pulse counts as the first of a sequence.
- R2: In call style (`mode86_i`=0), a master on the first pulse drives the opcode byte 0xCD.
- R3: In call style with `int4_i`=1, the second pulse returns {`call_lo_i`[2:0], level, 2'b00}.
- R4: In call style with `int4_i`=0, the second pulse returns {`call_lo_i`[2:1], level, 3'b000}; `call_lo_i`[0] has no effect.
- R5: In call style, the third pulse returns `vec_hi_i` unchanged.
- R6: In vector style (`mode86_i`=1), the first pulse drives nothing. The second pulse returns {`vec_hi_i`[7:3], level}, and `int4_i` and `call_lo_i` have no effect.
- R7: `seq_end_o` is high for exactly one cycle, on the last pulse only (third in call style, second in vector style). The following pulse then starts a new sequence.
- R8: The level and processor style are sampled on the first pulse. Changes to `lvl_i` or `mode86_i` later in the sequence have no effect.
- R9: A master (`is_slave_i`=0) with `cas_hit_i`=1 still drives the opcode but does not drive the address or vector bytes.
- R10: A slave (`is_slave_i`=1) never drives the opcode. It drives the address or vector bytes only when `cas_hit_i`=1.
- R11: The drive enable rises in the cycle after the pulse's rising edge is sampled. It stays high, with the byte stable, while `ack_i` stays high, and falls in the cycle after `ack_i` is seen low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_i | input | 1 | Acknowledge strobe, active high |
| lvl_i | input | 3 | Resolved interrupt level |
| call_lo_i | input | 3 | Programmed call address bits A7..A5 |
| vec_hi_i | input | 8 | Programmed high address byte / vector base |
| int4_i | input | 1 | 1: call interval 4, 0: interval 8 |
| mode86_i | input | 1 | 1: vector style, 0: call style |
| is_slave_i | input | 1 | 1: this unit is a cascaded slave |
| cas_hit_i | input | 1 | Master: level owned by a slave; slave: this slave selected |
| byte_o | output | 8 | Byte presented on the bus |
| drv_en_o | output | 1 | Bus drive enable |
| seq_end_o | output | 1 | One-cycle strobe on the last acknowledge |

## Verification
The bench targets the interval-8 low byte with level 7 and ignored bit A5. A wrong shift there would set a zero bit or lose the top base bit. It also drives a vector-style sequence with nonzero low base bits and varies the level and style between pulses. A design that resampled them would switch its pulse count or send the wrong level. Long acknowledge pulses show whether the sequence-end strobe fires twice or the drive drops early. Cascade role combinations show whether a slave leaks the opcode or a master fails to step aside on address bytes.

// File: rtl/ivg_pkg.sv
package ivg_pkg;
  localparam int LVL_W  = 3;
  localparam int BYTE_W = 8;
  localparam int LO_W   = BYTE_W - LVL_W - 2;
  localparam int PH_W   = 2;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [LVL_W-1:0]  lvl_t;
  typedef logic [LO_W-1:0]   lo_t;
  typedef logic [PH_W-1:0]   phase_t;

  typedef enum logic [1:0] {
    SLOT_QUIET  = 2'd0,
    SLOT_OPCODE = 2'd1,
    SLOT_TARGET = 2'd2
  } slot_e;
endpackage

// File: rtl/ivg_seq_track.sv
module ivg_seq_track
  import ivg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ack_i,
  input  logic   mode86_i,
  input  lvl_t   lvl_i,
  output logic   rise_o,
  output phase_t phase_o,
  output logic   last_o,
  output logic   mode_o,
  output lvl_t   lvl_o
);
  logic   ack_q;
  phase_t ph_q, ph_d;
  logic   mode_q, mode_d;
  lvl_t   lvl_q, lvl_d;
  logic   first;

  always_comb begin
    rise_o  = ack_i & ~ack_q;
    first   = (ph_q == '0);
    mode_o  = first ? mode86_i : mode_q;
    lvl_o   = first ? lvl_i : lvl_q;
    last_o  = mode_o ? (ph_q == phase_t'(1)) : (ph_q == phase_t'(2));
    phase_o = ph_q;
    ph_d    = ph_q;
    mode_d  = mode_q;
    lvl_d   = lvl_q;
    if (rise_o) begin
      ph_d = last_o ? '0 : ph_q + phase_t'(1);
      if (first) begin
        mode_d = mode86_i;
        lvl_d  = lvl_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      ph_q   <= '0;
      mode_q <= 1'b0;
      lvl_q  <= '0;
    end else begin
      ack_q  <= ack_i;
      ph_q   <= ph_d;
      mode_q <= mode_d;
      lvl_q  <= lvl_d;
    end
  end

  AST_PHASE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q != phase_t'(3)); // R7
  AST_VEC_TWO_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == phase_t'(2)) |-> !mode_q); // R7
endmodule

// File: rtl/ivg_byte_fmt.sv
module ivg_byte_fmt
  import ivg_pkg::*;
#(
  parameter byte_t CALL_OPCODE = 8'hCD
) (
  input  phase_t phase_i,
  input  logic   mode86_i,
  input  logic   int4_i,
  input  lvl_t   lvl_i,
  input  lo_t    call_lo_i,
  input  byte_t  vec_hi_i,
  output byte_t  byte_o,
  output slot_e  slot_o
);
  localparam int VEC_TOP = BYTE_W - LVL_W;

  byte_t lo_int4, lo_int8, vec_byte;

  always_comb begin
    lo_int4  = {call_lo_i, lvl_i, 2'b00};
    lo_int8  = {call_lo_i[LO_W-1:1], lvl_i, 3'b000};
    vec_byte = {vec_hi_i[BYTE_W-1:LVL_W], lvl_i};
    byte_o   = '0;
    slot_o   = SLOT_QUIET;
    if (mode86_i) begin
      if (phase_i == phase_t'(1)) begin
        byte_o = vec_byte;
        slot_o = SLOT_TARGET;
      end
    end else begin
      case (phase_i)
        phase_t'(0): begin byte_o = CALL_OPCODE; slot_o = SLOT_OPCODE; end
        phase_t'(1): begin byte_o = int4_i ? lo_int4 : lo_int8; slot_o = SLOT_TARGET; end
        phase_t'(2): begin byte_o = vec_hi_i; slot_o = SLOT_TARGET; end
        default:     begin byte_o = '0; slot_o = SLOT_QUIET; end
      endcase
    end
  end

  initial begin
    assert (VEC_TOP == 5) else $error("vector split width"); // R6
  end
endmodule

// File: rtl/ivg_drive_ctl.sv
module ivg_drive_ctl
  import ivg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ack_i,
  input  logic  rise_i,
  input  logic  last_i,
  input  slot_e slot_i,
  input  byte_t byte_i,
  input  logic  is_slave_i,
  input  logic  cas_hit_i,
  output byte_t byte_o,
  output logic  drv_o,
  output logic  end_o
);
  logic  own;
  logic  drv_d, end_d;
  byte_t byte_d;

  always_comb begin
    case (slot_i)
      SLOT_OPCODE: own = ~is_slave_i;
      SLOT_TARGET: own = is_slave_i ? cas_hit_i : ~cas_hit_i;
      default:     own = 1'b0;
    endcase
    drv_d  = rise_i ? own : (drv_o & ack_i);
    byte_d = rise_i ? (own ? byte_i : '0) : byte_o;
    end_d  = rise_i & last_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_o  <= 1'b0;
      byte_o <= '0;
      end_o  <= 1'b0;
    end else begin
      drv_o  <= drv_d;
      byte_o <= byte_d;
      end_o  <= end_d;
    end
  end

  AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |=> !end_o); // R7
  AST_DRIVE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> !drv_o); // R11
  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_o && ack_i && !rise_i) |=> $stable(byte_o)); // R11
  AST_QUIET_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && slot_i == SLOT_QUIET) |=> !drv_o); // R6
endmodule

// File: rtl/ivg_ack_vector.sv
module ivg_ack_vector
  import ivg_pkg::*;
#(
  parameter byte_t CALL_OPCODE = 8'hCD
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ack_i,
  input  logic [2:0]  lvl_i,
  input  logic [2:0]  call_lo_i,
  input  logic [7:0]  vec_hi_i,
  input  logic        int4_i,
  input  logic        mode86_i,
  input  logic        is_slave_i,
  input  logic        cas_hit_i,
  output logic [7:0]  byte_o,
  output logic        drv_en_o,
  output logic        seq_end_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic   rise, last, mode_cur;
  phase_t phase;
  lvl_t   lvl_cur;
  byte_t  fmt_byte;
  slot_e  slot;

  ivg_seq_track u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ack_i    (ack_i),
    .mode86_i (mode86_i),
    .lvl_i    (lvl_i),
    .rise_o   (rise),
    .phase_o  (phase),
    .last_o   (last),
    .mode_o   (mode_cur),
    .lvl_o    (lvl_cur)
  );

  ivg_byte_fmt #(.CALL_OPCODE(CALL_OPCODE)) u_fmt (
    .phase_i   (phase),
    .mode86_i  (mode_cur),
    .int4_i    (int4_i),
    .lvl_i     (lvl_cur),
    .call_lo_i (call_lo_i),
    .vec_hi_i  (vec_hi_i),
    .byte_o    (fmt_byte),
    .slot_o    (slot)
  );

  ivg_drive_ctl u_drv (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ack_i      (ack_i),
    .rise_i     (rise),
    .last_i     (last),
    .slot_i     (slot),
    .byte_i     (fmt_byte),
    .is_slave_i (is_slave_i),
    .cas_hit_i  (cas_hit_i),
    .byte_o     (byte_o),
    .drv_o      (drv_en_o),
    .end_o      (seq_end_o)
  );

  AST_MASTER_YIELDS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rise && phase != '0 && !is_slave_i && cas_hit_i) |=> !drv_en_o); // R9
  AST_SLAVE_NO_OPCODE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rise && phase == '0 && is_slave_i) |=> !drv_en_o); // R10
endmodule

// File: tb/ivg_ack_vector_tb.sv
module ivg_ack_vector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SEED       = 32'h5EED_0C59;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ack_i;
  logic [2:0] lvl_i;
  logic [2:0] call_lo_i;
  logic [7:0] vec_hi_i;
  logic       int4_i, mode86_i, is_slave_i, cas_hit_i;
  logic [7:0] byte_o;
  logic       drv_en_o, seq_end_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivg_ack_vector dut_i (
    .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .lvl_i(lvl_i),
    .call_lo_i(call_lo_i), .vec_hi_i(vec_hi_i), .int4_i(int4_i),
    .mode86_i(mode86_i), .is_slave_i(is_slave_i), .cas_hit_i(cas_hit_i),
    .byte_o(byte_o), .drv_en_o(drv_en_o), .seq_end_o(seq_end_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int p, input bit m86, input bit i4,
                                          input logic [2:0] lv, input logic [2:0] lo,
                                          input logic [7:0] hi);
    if (m86)    return {hi[7:3], lv};
    if (p == 0) return 8'hCD;
    if (p == 1) return i4 ? {lo, lv, 2'b00} : {lo[2:1], lv, 3'b000};
    return hi;
  endfunction

  function automatic bit exp_own(input int p, input bit m86, input bit sl, input bit ch);
    if (p == 0) return m86 ? 1'b0 : !sl;
    return sl ? ch : !ch;
  endfunction

  task automatic run_seq(input bit m86, input bit i4, input logic [2:0] lv,
                         input logic [2:0] lo, input logic [7:0] hi,
                         input bit sl, input bit ch, input int hold);
    int n;
    n = m86 ? 2 : 3;
    mode86_i = m86; int4_i = i4; lvl_i = lv; call_lo_i = lo;
    vec_hi_i = hi; is_slave_i = sl; cas_hit_i = ch;
    for (int p = 0; p < n; p++) begin
      string tag;
      bit own;
      logic [7:0] eb;
      own = exp_own(p, m86, sl, ch);
      eb  = exp_byte(p, m86, i4, lv, lo, hi);
      if (sl)                 tag = "R10";
      else if (ch && p != 0)  tag = "R9";
      else if (m86)           tag = "R6";
      else if (p == 0)        tag = "R2";
      else if (p == 1)        tag = i4 ? "R3" : "R4";
      else                    tag = "R5";
      if (p != 0) tag = {tag, "/R8"};
      ack_i = 1'b1;
      @(negedge clk);
      chk({tag, " drive"}, int'(drv_en_o), int'(own));
      if (own) chk({tag, " byte"}, int'(byte_o), int'(eb));
      chk("R7 end strobe", int'(seq_end_o), int'(p == n - 1));
      for (int h = 1; h < hold; h++) begin
        @(negedge clk);
        chk("R11 held drive", int'(drv_en_o), int'(own));
        chk("R7 end single cycle", int'(seq_end_o), 0);
        if (own) chk("R11 held byte", int'(byte_o), int'(eb));
      end
      ack_i = 1'b0;
      lvl_i = 3'($urandom);
      mode86_i = 1'($urandom);
      @(negedge clk);
      chk("R11 release", int'(drv_en_o), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(SEED));
    rst_n = 1'b0; ack_i = 1'b0; lvl_i = '0; call_lo_i = '0; vec_hi_i = '0;
    int4_i = 1'b0; mode86_i = 1'b0; is_slave_i = 1'b0; cas_hit_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset drive", int'(drv_en_o), 0);
    chk("R1 reset end", int'(seq_end_o), 0);
    chk("R1 reset byte", int'(byte_o), 0);

    run_seq(1'b0, 1'b1, 3'd7, 3'b101, 8'h12, 1'b0, 1'b0, 1);
    run_seq(1'b0, 1'b0, 3'd7, 3'b011, 8'hFF, 1'b0, 1'b0, 3);
    run_seq(1'b0, 1'b0, 3'd0, 3'b111, 8'h00, 1'b0, 1'b0, 2);
    run_seq(1'b1, 1'b1, 3'd5, 3'b111, 8'hA8, 1'b0, 1'b0, 2);
    run_seq(1'b1, 1'b0, 3'd0, 3'b000, 8'hFF, 1'b0, 1'b0, 1);
    run_seq(1'b0, 1'b1, 3'd3, 3'b010, 8'h40, 1'b0, 1'b1, 2);
    run_seq(1'b0, 1'b1, 3'd3, 3'b010, 8'h40, 1'b1, 1'b1, 2);
    run_seq(1'b0, 1'b0, 3'd6, 3'b110, 8'h9C, 1'b1, 1'b0, 1);
    run_seq(1'b1, 1'b0, 3'd2, 3'b001, 8'h78, 1'b1, 1'b1, 1);
    run_seq(1'b1, 1'b0, 3'd2, 3'b001, 8'h78, 1'b0, 1'b1, 1);

    for (int k = 0; k < 40; k++) begin
      run_seq(1'($urandom), 1'($urandom), 3'($urandom), 3'($urandom),
              8'($urandom), 1'($urandom), 1'($urandom), 1 + int'($urandom % 3));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog R7 actual=timeout expected=sequence completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule